// File: doc/BRIEF.md
# Per-CPU Interrupt Wake Generator

This block sits next to a shared interrupt controller. Every incoming level interrupt line goes straight through to that controller, whatever the wake settings. Alongside that path, the block keeps one bank of wake-enable bits per CPU. It raises a registered wake request for each CPU when an enabled line is active.

Host software programs the enable banks and a coupling-mode register through a 32-bit APB-style register port. In independent mode, each CPU wakes only on its own enabled lines. In coupled mode, the two cores enter and leave their off state together, so any source enabled for either CPU wakes both. The number of 32-line banks is a parameter (4, 5 or 7). With 7 banks, only CPU0 has an enable set.

Top module: `wake_gen_top`

## Requirements
- R1: `irq_o` equals `irq_i` in every cycle, independent of enables, mode and reset.
- R2: Line n is controlled by bank n/32, bit n mod 32. CPU0 bank k sits at byte offset 4k. CPU1 bank k sits at offset 0x400 + 4k.
- R3: A line raises a CPU's wake request only when that CPU's enable bit for the line is 1. A bit of 0 blocks it. `wake_o` is registered and reflects `irq_i` and the enables one clock edge later.
- R4: When bit 5 of the mode register (offset 0x800) is 1, `wake_o[c]` depends only on CPU c's enables.
- R5: When that mode bit is 0, a line enabled for either CPU asserts both bits of `wake_o`.
- R6: After reset, all enable bits are 0, the mode bit is 0 and `wake_o` is 0.
- R7: A write takes effect when `psel_i`, `penable_i` and `pwrite_i` are all high at a clock edge. Each bank reads back the full 32-bit value last written. The mode register reads back only bit 5; all its other bits read 0.
- R8: The following offsets are unimplemented: misaligned offsets, bank indices at or above the bank count, and all other offsets from 0x800 upward except 0x800 itself. Reads of these offsets return 0, and writes to them change no state.
- R9: With 7 banks, the CPU1 offsets are unimplemented, so CPU1 wakes only through coupled mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psel_i | input | 1 | Register select |
| penable_i | input | 1 | Access phase |
| pwrite_i | input | 1 | 1 = write |
| paddr_i | input | 12 | Byte offset |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data (combinational from `paddr_i`) |
| irq_i | input | NUM_BANKS*32 | Incoming interrupt lines |
| irq_o | output | NUM_BANKS*32 | Lines passed to the interrupt controller |
| wake_o | output | 2 | Per-CPU wake requests |

## Verification
The hardest case to reach is coupled mode where a line is enabled only in CPU1's bank, while CPU0's bank is clear. In that case CPU0 must still wake. The stimulus builds this state by writing the two banks with disjoint patterns and toggling the mode bit while the line stays high.

A second instance with 7 banks is driven from the same bus. It shows that the missing CPU1 set reads as zero and still lets CPU1 wake through coupling. A behavioural model checks the wake outputs of both instances on every clock, across random line patterns mixed with random register writes.

// File: rtl/wg_pkg.sv
package wg_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned NUM_CPUS  = 2;
  localparam logic [ADDR_W-1:0] MODE_ADDR = 12'h800;
  localparam int unsigned MODE_BIT  = 5;
endpackage

// File: rtl/wg_regs.sv
module wg_regs
  import wg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 5,
  localparam int unsigned NUM_LINES = NUM_BANKS * WORD_W,
  localparam int unsigned NUM_SETS  = (NUM_BANKS == 7) ? 1 : 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [WORD_W-1:0]            wdata_i,
  output logic [WORD_W-1:0]            rdata_o,
  output logic [NUM_CPUS-1:0][NUM_LINES-1:0] en_o,
  output logic                         mode_o
);
  logic       cpu_sel;
  logic [7:0] bank_idx;
  logic       set_ok, bank_hit, mode_hit;

  assign cpu_sel  = addr_i[10];
  assign bank_idx = addr_i[9:2];
  assign set_ok   = !cpu_sel || (NUM_SETS == 2);
  assign bank_hit = !addr_i[11] && (addr_i[1:0] == 2'b00) &&
                    (bank_idx < 8'(NUM_BANKS)) && set_ok;
  assign mode_hit = (addr_i == MODE_ADDR);

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      if (c < NUM_SETS) begin : g_impl
        logic [WORD_W-1:0] bank_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) bank_q <= '0;
          else if (wr_i && bank_hit && (cpu_sel == 1'(c)) && (bank_idx == 8'(b)))
            bank_q <= wdata_i;
        end
        assign en_o[c][b*WORD_W +: WORD_W] = bank_q;
      end else begin : g_none
        assign en_o[c][b*WORD_W +: WORD_W] = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_o <= 1'b0;
    else if (wr_i && mode_hit) mode_o <= wdata_i[MODE_BIT];
  end

  always_comb begin
    rdata_o = '0;
    if (mode_hit) rdata_o[MODE_BIT] = mode_o;
    else if (bank_hit) begin
      for (int b = 0; b < NUM_BANKS; b++)
        if (bank_idx == 8'(b)) rdata_o = en_o[cpu_sel][b*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/wg_gate.sv
module wg_gate
  import wg_pkg::*;
#(
  parameter int unsigned NUM_LINES = 160
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [NUM_LINES-1:0]               irq_i,
  input  logic [NUM_CPUS-1:0][NUM_LINES-1:0] en_i,
  input  logic                               indep_i,
  output logic [NUM_CPUS-1:0]                wake_o
);
  logic [NUM_CPUS-1:0] raw, nxt;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_or
    assign raw[c] = |(irq_i & en_i[c]);
  end

  // coupled cores share one wake decision
  assign nxt = indep_i ? raw : {NUM_CPUS{|raw}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_o <= '0;
    else         wake_o <= nxt;
  end
endmodule

// File: rtl/wake_gen_top.sv
module wake_gen_top
  import wg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 5,
  localparam int unsigned NUM_LINES = NUM_BANKS * WORD_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 psel_i,
  input  logic                 penable_i,
  input  logic                 pwrite_i,
  input  logic [11:0]          paddr_i,
  input  logic [31:0]          pwdata_i,
  output logic [31:0]          prdata_o,
  input  logic [NUM_LINES-1:0] irq_i,
  output logic [NUM_LINES-1:0] irq_o,
  output logic [1:0]           wake_o
);
  logic                               wr;
  logic                               mode_q;
  logic [NUM_CPUS-1:0][NUM_LINES-1:0] en;

  assign wr    = psel_i && penable_i && pwrite_i;
  assign irq_o = irq_i;

  wg_regs #(.NUM_BANKS(NUM_BANKS)) regs_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .addr_i(paddr_i),
    .wdata_i(pwdata_i), .rdata_o(prdata_o), .en_o(en), .mode_o(mode_q)
  );

  wg_gate #(.NUM_LINES(NUM_LINES)) gate_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .en_i(en),
    .indep_i(mode_q), .wake_o(wake_o)
  );
endmodule

// File: rtl/wg_chk.sv
module wg_chk #(
  parameter int unsigned NUM_LINES = 160
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr,
  input logic [11:0]          paddr_i,
  input logic [31:0]          prdata_o,
  input logic [NUM_LINES-1:0] irq_i,
  input logic [1:0]           wake_o,
  input logic                 mode_q
);
  p_coupled_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q |=> (wake_o[0] == wake_o[1]));

  p_idle_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i == '0) |=> (wake_o == 2'b00));

  p_mode_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && paddr_i == 12'h800) |=> $stable(mode_q));

  p_unmapped_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paddr_i[11:10] == 2'b11) |-> (prdata_o == 32'h0));

  p_misaligned_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paddr_i[1:0] != 2'b00) |-> (prdata_o == 32'h0));
endmodule

bind wake_gen_top wg_chk #(.NUM_LINES(NUM_LINES)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr(wr), .paddr_i(paddr_i),
  .prdata_o(prdata_o), .irq_i(irq_i), .wake_o(wake_o), .mode_q(mode_q)
);

// File: tb/wake_gen_top_tb_top.sv
module wake_gen_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0]  paddr = '0;
  logic [31:0]  pwdata = '0;
  logic [223:0] irq = '0;
  logic [31:0]  rd5, rd7;
  logic [159:0] irq_o5;
  logic [223:0] irq_o7;
  logic [1:0]   wk5, wk7;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_gen_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(rd5),
    .irq_i(irq[159:0]), .irq_o(irq_o5), .wake_o(wk5)
  );

  wake_gen_top #(.NUM_BANKS(7)) dut7_i (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(rd7),
    .irq_i(irq), .irq_o(irq_o7), .wake_o(wk7)
  );

  // reference model: d=0 five banks two CPUs, d=1 seven banks one CPU
  logic [31:0] m_en [2][2][7];
  logic        m_mode [2];
  logic [1:0]  m_wake [2];
  int          nb [2] = '{5, 7};
  int          ncpu [2] = '{2, 1};

  function automatic int decode(int d, logic [11:0] a, output int cpu, output int bank);
    int ia = int'(a);
    cpu = 0; bank = 0;
    if (ia == 2048) return 2;
    if ((ia % 4) != 0 || ia >= 2048) return 0;
    cpu  = ia / 1024;
    bank = (ia % 1024) / 4;
    if (bank >= nb[d] || cpu >= ncpu[d]) return 0;
    return 1;
  endfunction

  function automatic logic [31:0] model_read(int d, logic [11:0] a);
    int cpu, bank, k;
    k = decode(d, a, cpu, bank);
    if (k == 2) return m_mode[d] ? 32'h20 : 32'h0;
    if (k == 1) return m_en[d][cpu][bank];
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < 2; d++) begin
        m_mode[d] = 0; m_wake[d] = 2'b00;
        for (int c = 0; c < 2; c++) for (int b = 0; b < 7; b++) m_en[d][c][b] = 0;
      end
    end else begin
      for (int d = 0; d < 2; d++) begin
        logic [1:0] hit;
        hit = 2'b00;
        for (int c = 0; c < 2; c++)
          for (int b = 0; b < nb[d]; b++)
            if ((irq[b*32 +: 32] & m_en[d][c][b]) != 0) hit[c] = 1'b1;
        m_wake[d] = m_mode[d] ? hit : (hit != 0 ? 2'b11 : 2'b00);
      end
      if (psel && penable && pwrite)
        for (int d = 0; d < 2; d++) begin
          int cpu, bank, k;
          k = decode(d, paddr, cpu, bank);
          if (k == 2) m_mode[d] = pwdata[5];
          else if (k == 1) m_en[d][cpu][bank] = pwdata;
        end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // every-clock comparison
  always @(negedge clk) if (rst_n && !done) begin
    check(m_mode[0] ? "R4 wake dut" : "R5 wake dut", 32'(wk5), 32'(m_wake[0]));
    check(m_mode[1] ? "R4 wake dut7" : "R9 wake dut7", 32'(wk7), 32'(m_wake[1]));
    check("R1 pass-through", 32'(irq_o5 != irq[159:0]), 32'h0);
    check("R1 pass-through 7", 32'(irq_o7 != irq), 32'h0);
  end

  task automatic wr_reg(logic [11:0] a, logic [31:0] v);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = v;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd_reg(string tag, logic [11:0] a);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a;
    #1;
    check(tag, rd5, model_read(0, a));
    check({tag, " dut7"}, rd7, model_read(1, a));
    @(negedge clk); psel = 0;
  endtask

  task automatic set_irq(logic [223:0] v);
    @(negedge clk); irq = v;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R6 reset wake", 32'(wk5), 32'h0);
    check("R6 reset bank", rd5, 32'h0);
    rst_n = 1;
    rd_reg("R6 mode reset", 12'h800);
    rd_reg("R6 cpu1 bank reset", 12'h410);

    // R2/R5: line 40 -> bank1 bit8 of CPU0, coupled wakes both
    wr_reg(12'h004, 32'h0000_0100);
    set_irq(224'(1) << 40);
    check("R5 coupled both", 32'(wk5), 32'h3);
    // R2: line 63 is bank1 bit31, not enabled
    set_irq(224'(1) << 63);
    check("R3 blocked", 32'(wk5), 32'h0);
    // R5: line enabled only for CPU1
    wr_reg(12'h410, 32'h0000_0004);
    set_irq(224'(1) << 130);
    check("R5 cpu1-only src wakes both", 32'(wk5), 32'h3);
    // R4: independent mode
    wr_reg(12'h800, 32'h0000_0020);
    rd_reg("R7 mode readback", 12'h800);
    @(negedge clk);
    check("R4 cpu1 only", 32'(wk5), 32'h2);
    set_irq(224'(1) << 40);
    check("R4 cpu0 only", 32'(wk5), 32'h1);
    // R3: mask everything in bank1
    wr_reg(12'h004, 32'h0);
    @(negedge clk);
    check("R3 masked", 32'(wk5), 32'h0);
    // R7: readback patterns
    wr_reg(12'h000, 32'hA5A5_5A5A); rd_reg("R7 bank0", 12'h000);
    wr_reg(12'h40C, 32'hFFFF_FFFF); rd_reg("R7 cpu1 bank3", 12'h40C);
    wr_reg(12'h010, 32'h8000_0001); rd_reg("R7 bank4", 12'h010);
    // R8: unimplemented
    wr_reg(12'h014, 32'hDEAD_BEEF); rd_reg("R8 bank5 on 5-bank", 12'h014);
    wr_reg(12'h002, 32'h1234_5678); rd_reg("R8 misaligned", 12'h002);
    rd_reg("R8 bank0 untouched", 12'h000);
    wr_reg(12'hC00, 32'hFFFF_FFFF); rd_reg("R8 high offset", 12'hC00);
    wr_reg(12'h804, 32'h0);          rd_reg("R8 mode unchanged", 12'h800);
    wr_reg(12'h800, 32'hFFFF_FFDF);  rd_reg("R7 mode bit only", 12'h800);
    // R9: seven-bank instance
    wr_reg(12'h418, 32'hFFFF_FFFF); rd_reg("R9 cpu1 absent", 12'h418);
    wr_reg(12'h018, 32'h0000_0100); rd_reg("R9 bank6", 12'h018);
    set_irq(224'(1) << 200);
    check("R9 coupled cpu1 via cpu0", 32'(wk7), 32'h3);
    wr_reg(12'h800, 32'h20);
    @(negedge clk);
    check("R9 independent cpu1 never", 32'(wk7), 32'h1);
    // random traffic, checked every clock by the model
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      irq = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      if (($urandom % 4) == 0) begin
        logic [11:0] a;
        a = 12'(($urandom % 2) * 12'h400 + ($urandom % 8) * 4);
        if (($urandom % 8) == 0) a = 12'h800;
        wr_reg(a, $urandom & $urandom);
        rd_reg("R7 random readback", a);
      end
    end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule